// File: doc/BRIEF.md
# Serial Configuration Register Loader

This block is a two-wire serial slave that only takes block writes and loads them into a small bank of 8-bit configuration registers. It watches the clock and data lines of a two-wire management bus, matches its fixed device address in write direction, and then acknowledges every byte that follows. The first two bytes after the address are a command byte and a length byte. Both must be sent and both are acknowledged, but neither changes where data lands.

Every later data byte is written into the next register, starting at register 0. A stop condition after any complete byte ends the update. A new start condition, including a repeated start, begins a fresh transaction at register 0. The register contents leave the block as one flat vector that drives clock-output enables and frequency overrides elsewhere on the chip. The only drive back onto the bus is a pull-low request for the acknowledge bit.

Top module: `smb_cfg_slave`

## Requirements
- R1: After reset, the registers hold, from index 0 upward: 0x06, 0xFF, 0x7F, 0x8A, 0x00, 0x00, 0x06, and 0x00 for every index from 7 upward. Register i appears on `cfg_out[8*i+7:8*i]`.
- R2: The address byte 0xD2 is acknowledged. This is the 7-bit address 1101001 followed by a 0 write bit. Acknowledge means `sda_pull` is 1 while SCL is high on the ninth clock of the byte.
- R3: Any other address byte is not acknowledged, including the read form 0xD3. After such a byte, no later byte is acknowledged and no register changes until the next start condition.
- R4: The command byte and the length byte are both acknowledged whatever their values, including a length of 0. Their values have no effect on which registers are written.
- R5: Data bytes are written to registers 0, 1, 2 and onward in arrival order, one register per byte, and every data byte is acknowledged.
- R6: Bits within a byte arrive most significant bit first.
- R7: A stop condition after a complete byte ends the transfer. Registers that were not reached keep their values.
- R8: Data bytes beyond the last implemented register are acknowledged and discarded.
- R9: A start condition that arrives in the middle of a transfer (a repeated start) restarts address matching, and the next data byte goes to register 0.
- R10: `sda_pull` only changes while SCL is low. It is 0 during the data bits of every byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line as seen at the pad (asynchronous) |
| sda_in | input | 1 | Serial data line as seen at the pad (asynchronous) |
| sda_pull | output | 1 | 1 requests the pad to pull the data line low (acknowledge) |
| cfg_out | output | NUM_REGS*8 | Register contents; register i in bits 8*i+7:8*i |

## Verification
The checker assumes that every SCL high or low phase lasts well beyond the synchronizer latency, about four system clocks. Under that assumption, a change on the synchronized side of the block still falls within the same raw SCL level that caused it. It also assumes that the bus master changes SDA only while SCL is low, except for start and stop conditions. The bench drives every bit phase for eight system clocks and moves SDA only in the middle of the SCL low time. It builds start and stop conditions only while SCL is held high, so the stimulus meets both assumptions throughout.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_CMD,
    PH_LEN,
    PH_DATA,
    PH_SKIP
  } phase_t;

  // Power-on contents of one configuration register.
  function automatic logic [7:0] reset_byte(input int idx);
    case (idx)
      0:       reset_byte = 8'h06;
      1:       reset_byte = 8'hFF;
      2:       reset_byte = 8'h7F;
      3:       reset_byte = 8'h8A;
      6:       reset_byte = 8'h06;
      default: reset_byte = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_d;
  logic              sda_d;
  logic              scl_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_pipe <= 1'b1;
          sda_pipe <= 1'b1;
        end else begin
          scl_pipe <= scl_in;
          sda_pipe <= sda_in;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
          sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
        end
      end
    end
  endgenerate

  assign scl_q = scl_pipe[STAGES-1];
  assign sda_q = sda_pipe[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_q;
      sda_d <= sda_q;
    end
  end

  assign scl_rise  =  scl_q & ~scl_d;
  assign scl_fall  = ~scl_q &  scl_d;
  assign start_det =  scl_q &  scl_d &  sda_d & ~sda_q;
  assign stop_det  =  scl_q &  scl_d & ~sda_d &  sda_q;

endmodule

// File: rtl/smb_byte_engine.sv
module smb_byte_engine
  import smb_cfg_pkg::*;
#(
  parameter int         NUM_REGS = 8,
  parameter logic [6:0] DEV_ADDR = 7'b1101001,
  localparam int        IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int        PTR_W    = $clog2(NUM_REGS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sda_q,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  output logic             sda_pull,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_data
);

  localparam logic [7:0] WR_ADDR_BYTE = {DEV_ADDR, 1'b0};

  phase_t           phase;
  phase_t           nxt;
  logic [3:0]       bit_cnt;
  logic             in_ack;
  logic [7:0]       shreg;
  logic [7:0]       byte_nx;
  logic [PTR_W-1:0] ptr;
  logic             active;

  assign byte_nx = {shreg[6:0], sda_q};
  assign active  = (phase != PH_IDLE) && (phase != PH_SKIP);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      nxt      <= PH_IDLE;
      bit_cnt  <= '0;
      in_ack   <= 1'b0;
      shreg    <= '0;
      ptr      <= '0;
      sda_pull <= 1'b0;
      wr_en    <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        phase    <= PH_ADDR;
        bit_cnt  <= '0;
        in_ack   <= 1'b0;
        sda_pull <= 1'b0;
        ptr      <= '0;
      end else if (stop_det) begin
        phase    <= PH_IDLE;
        bit_cnt  <= '0;
        in_ack   <= 1'b0;
        sda_pull <= 1'b0;
      end else if (active) begin
        if (scl_rise && (bit_cnt < 4'd8)) begin
          shreg   <= byte_nx;
          bit_cnt <= bit_cnt + 4'd1;
          if (bit_cnt == 4'd7) begin
            case (phase)
              PH_ADDR: begin
                if (byte_nx == WR_ADDR_BYTE) nxt <= PH_CMD;
                else                         phase <= PH_SKIP;
              end
              PH_CMD:  nxt <= PH_LEN;
              PH_LEN:  nxt <= PH_DATA;
              PH_DATA: begin
                nxt <= PH_DATA;
                if (ptr < PTR_W'(NUM_REGS)) begin
                  wr_en   <= 1'b1;
                  wr_idx  <= ptr[IDX_W-1:0];
                  wr_data <= byte_nx;
                  ptr     <= ptr + 1'b1;
                end
              end
              default: phase <= PH_SKIP;
            endcase
          end
        end else if (scl_fall && (bit_cnt == 4'd8)) begin
          if (!in_ack) begin
            in_ack   <= 1'b1;
            sda_pull <= 1'b1;
          end else begin
            in_ack   <= 1'b0;
            sda_pull <= 1'b0;
            bit_cnt  <= '0;
            phase    <= nxt;
          end
        end
      end
    end
  end

endmodule

// File: rtl/smb_cfg_bank.sv
module smb_cfg_bank
  import smb_cfg_pkg::*;
#(
  parameter  int NUM_REGS = 8,
  localparam int IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [7:0]            wr_data,
  output logic [NUM_REGS*8-1:0] cfg_out
);

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst)
          cfg_out[8*g +: 8] <= reset_byte(g);
        else if (wr_en && (wr_idx == IDX_W'(g)))
          cfg_out[8*g +: 8] <= wr_data;
      end
    end
  endgenerate

endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave #(
  parameter int         NUM_REGS    = 8,
  parameter logic [6:0] DEV_ADDR    = 7'b1101001,
  parameter int         SYNC_STAGES = 2,
  localparam int        IDX_W       = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  scl_in,
  input  logic                  sda_in,
  output logic                  sda_pull,
  output logic [NUM_REGS*8-1:0] cfg_out
);

  logic             sda_q;
  logic             scl_rise;
  logic             scl_fall;
  logic             start_det;
  logic             stop_det;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [7:0]       wr_data;

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .sda_q     (sda_q),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  smb_byte_engine #(.NUM_REGS(NUM_REGS), .DEV_ADDR(DEV_ADDR)) u_engine (
    .clk       (clk),
    .rst       (rst),
    .sda_q     (sda_q),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_pull  (sda_pull),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data)
  );

  smb_cfg_bank #(.NUM_REGS(NUM_REGS)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .cfg_out (cfg_out)
  );

endmodule

// File: rtl/smb_cfg_checker.sv
module smb_cfg_checker #(
  parameter int NUM_REGS = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  scl_in,
  input logic                  sda_pull,
  input logic [NUM_REGS*8-1:0] cfg_out
);

  logic [NUM_REGS*8-1:0] cfg_prev;
  logic [NUM_REGS-1:0]   chg;

  always_ff @(posedge clk) cfg_prev <= cfg_out;

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_chg
      assign chg[g] = (cfg_out[8*g +: 8] != cfg_prev[8*g +: 8]);
    end
  endgenerate

  // R5: one data byte updates exactly one register
  a_r5_single_register: assert property (@(posedge clk) disable iff (rst)
    $onehot0(chg));

  // R5: registers are written only at a byte boundary, while SCL is high
  a_r5_write_on_scl_high: assert property (@(posedge clk) disable iff (rst)
    (|chg) |-> scl_in);

  // R10: the acknowledge pull starts while SCL is low
  a_r10_pull_rises_scl_low: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pull) |-> !scl_in);

  // R10: the pull stays steady during a settled SCL high phase
  a_r10_pull_steady_high: assert property (@(posedge clk) disable iff (rst)
    (scl_in && $past(scl_in) && $past(scl_in, 2) && $past(scl_in, 3))
      |-> $stable(sda_pull));

endmodule

bind smb_cfg_slave smb_cfg_checker #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .scl_in   (scl_in),
  .sda_pull (sda_pull),
  .cfg_out  (cfg_out)
);

// File: tb/tb_smb_cfg_slave.sv
module tb_smb_cfg_slave;

  localparam int NREG = 8;
  localparam int Q    = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              scl_drv = 1'b1;
  logic              sda_drv = 1'b1;
  logic              sda_pull;
  logic [NREG*8-1:0] cfg_out;
  logic              sda_line;
  logic [7:0]        model [NREG];
  int                n_chk  = 0;
  int                n_fail = 0;
  bit                done   = 1'b0;

  always #4 clk = ~clk;

  assign sda_line = sda_drv & ~sda_pull;

  smb_cfg_slave dut (
    .clk      (clk),
    .rst      (rst),
    .scl_in   (scl_drv),
    .sda_in   (sda_line),
    .sda_pull (sda_pull),
    .cfg_out  (cfg_out)
  );

  function automatic logic [7:0] power_on(input int i);
    logic [7:0] v [7] = '{8'h06, 8'hFF, 8'h7F, 8'h8A, 8'h00, 8'h00, 8'h06};
    return (i < 7) ? v[i] : 8'h00;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; hold(Q);
    scl_drv = 1'b1; hold(Q);
    sda_drv = 1'b0; hold(Q);
    scl_drv = 1'b0; hold(Q);
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; hold(Q);
    scl_drv = 1'b1; hold(Q);
    sda_drv = 1'b1; hold(Q);
  endtask

  // Sends one byte MSB first (R6) and returns the ninth-clock acknowledge.
  task automatic put_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_drv = b[i]; hold(Q);
      scl_drv = 1'b1; hold(Q / 2);
      chk("R10 no pull in data bit", sda_pull, 1'b0);
      hold(Q / 2);
      scl_drv = 1'b0; hold(Q);
    end
    sda_drv = 1'b1; hold(Q);
    scl_drv = 1'b1; hold(Q / 2);
    acked = sda_pull;
    hold(Q / 2);
    scl_drv = 1'b0; hold(Q);
  endtask

  task automatic check_regs(input string req);
    for (int i = 0; i < NREG; i++) chk(req, cfg_out[8*i +: 8], model[i]);
  endtask

  // Full transaction: address, command, length, n data bytes base+i*step.
  task automatic wr_block(input logic [7:0] addr, input logic [7:0] cmd,
                          input logic [7:0] len, input int n,
                          input logic [7:0] base, input logic [7:0] step,
                          input bit do_stop);
    bit a;
    logic [7:0] d;
    bus_start();
    put_byte(addr, a);
    if (addr == 8'hD2) begin
      chk("R2 address ack", a, 1'b1);
      put_byte(cmd, a); chk("R4 command ack", a, 1'b1);
      put_byte(len, a); chk("R4 length ack", a, 1'b1);
      for (int i = 0; i < n; i++) begin
        d = base + 8'(i) * step;
        put_byte(d, a);
        if (i < NREG) begin
          chk("R5 data ack", a, 1'b1);
          model[i] = d;
        end else begin
          chk("R8 overflow ack", a, 1'b1);
        end
      end
    end else begin
      chk("R3 foreign address nack", a, 1'b0);
      put_byte(cmd, a); chk("R3 no ack after nack", a, 1'b0);
      put_byte(len, a); chk("R3 no ack after nack", a, 1'b0);
      for (int i = 0; i < n; i++) begin
        put_byte(base + 8'(i) * step, a);
        chk("R3 no ack after nack", a, 1'b0);
      end
    end
    if (do_stop) bus_stop();
  endtask

  initial begin
    for (int i = 0; i < NREG; i++) model[i] = power_on(i);
    hold(5);
    rst = 1'b0;
    hold(3);
    chk("R1 idle pull", sda_pull, 1'b0);
    check_regs("R1 reset value");

    // R5: several patterns filling every register
    for (int s = 0; s < 6; s++) begin
      wr_block(8'hD2, 8'h00, 8'(NREG), NREG, 8'(s * 61 + 5), 8'(s * 2 + 23), 1'b1);
      check_regs("R5 sequential fill");
    end

    // R6: bit order distinguishes 0x01 from 0x80
    wr_block(8'hD2, 8'h00, 8'h01, 1, 8'h01, 8'h00, 1'b1);
    chk("R6 msb first", cfg_out[7:0], 8'h01);
    wr_block(8'hD2, 8'h00, 8'h01, 1, 8'h80, 8'h00, 1'b1);
    chk("R6 msb first", cfg_out[7:0], 8'h80);
    wr_block(8'hD2, 8'h00, 8'h01, 1, 8'hC5, 8'h00, 1'b1);
    chk("R6 msb first", cfg_out[7:0], 8'hC5);

    // R7: stop after three bytes leaves the rest alone
    wr_block(8'hD2, 8'h00, 8'h03, 3, 8'h3C, 8'h11, 1'b1);
    check_regs("R7 partial update");

    // R4: odd command and length values, including zero length
    wr_block(8'hD2, 8'h5A, 8'h00, 2, 8'hE1, 8'h01, 1'b1);
    check_regs("R4 command/length ignored");
    wr_block(8'hD2, 8'hFF, 8'hFF, 1, 8'h77, 8'h00, 1'b1);
    check_regs("R4 command/length ignored");

    // R3: foreign and read addresses, with trailing bytes
    wr_block(8'hD3, 8'h00, 8'h02, 2, 8'h99, 8'h01, 1'b1);
    wr_block(8'hA4, 8'h00, 8'h02, 2, 8'h99, 8'h01, 1'b1);
    wr_block(8'h52, 8'h00, 8'h02, 2, 8'h99, 8'h01, 1'b1);
    wr_block(8'hD0, 8'h00, 8'h02, 2, 8'h99, 8'h01, 1'b1);
    check_regs("R3 registers untouched");

    // R2/R3: every possible address byte, acknowledge only for 0xD2
    for (int a = 0; a < 256; a++) begin
      bit ak;
      bus_start();
      put_byte(8'(a), ak);
      chk(a == 'hD2 ? "R2 address sweep" : "R3 address sweep", ak, (a == 'hD2));
      bus_stop();
    end
    check_regs("R3 registers after sweep");

    // R8: three bytes past the end are acknowledged and dropped
    wr_block(8'hD2, 8'h00, 8'(NREG + 3), NREG + 3, 8'h10, 8'h07, 1'b1);
    check_regs("R8 overflow discarded");

    // R9: repeated start restarts at register 0
    wr_block(8'hD2, 8'h00, 8'h02, 2, 8'hA0, 8'h0B, 1'b0);
    wr_block(8'hD2, 8'h00, 8'h01, 1, 8'h5D, 8'h00, 1'b1);
    chk("R9 restart at register 0", cfg_out[7:0], 8'h5D);
    chk("R9 register 1 from first part", cfg_out[15:8], 8'hAB);
    check_regs("R9 repeated start");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule